// File: doc/BRIEF.md
# Per-Core Performance Event Counter Unit

This block counts microarchitectural activity for one processor core. The core presents a vector of sixteen single-cycle event pulses. Four programmable 32-bit counters each pick one of those pulses through a 4-bit selector. A 64-bit cycle counter runs beside them and can step on every clock or once per 64 clocks. A master run bit gates all counting. A per-counter enable mask gates each counter on its own. Two write-one strobes zero the event counters or the cycle counter. Any counter that wraps past its maximum sets a sticky flag, and a level interrupt is raised for every flag whose interrupt mask bit is set.

Software reaches every register through a single-cycle word port: one write strobe with an address and data, and a read data bus that follows the address combinationally. Register state changes at the clock edge where a write is sampled. The core-side event pulses are sampled at the same edges, so a pulse at edge N shows in the count read after edge N.

Top module: `perfmon_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 at all sixteen addresses and `irq` is low.
- R2: Event counter i (value at address 8+i) rises by one after each edge where the run bit (CTRL bit 0, address 0) is 1, enable bit i is 1 and the selected event input is 1. Otherwise it holds.
- R3: The selector of counter i (address 12+i, bits [3:0]) names the index of the `events` bit that counter i counts. A new selector takes effect from the edge after the write.
- R4: With CTRL bit 3 at 0, the 64-bit cycle counter (low word at address 6, high word at address 7) rises by one after each edge where the run bit and enable bit 4 are both 1.
- R5: With CTRL bit 3 at 1, the cycle counter rises once per 64 edges on which it is enabled. After the cycle counter is cleared, its first step comes at the 64th such edge.
- R6: Writing 1 to CTRL bit 1 zeroes all event counters, and writing 1 to CTRL bit 2 zeroes the cycle counter and its divider. Either clear wins over an increment at the same edge. Both bits read 0, and writing 0 to them changes nothing.
- R7: Writing to address 1 sets, and writing to address 2 clears, exactly those enable bits (bits [4:0], bit 4 for the cycle counter) that are 1 in the data. Both addresses read the mask.
- R8: An event counter wraps from 0xFFFFFFFF to 0, and the cycle counter wraps from all ones to 0. Each wrap sets overflow flag i (bit 4 for the cycle counter) at address 5.
- R9: Overflow flags stay set until a 1 is written to their bit at address 5. Writing 0 leaves a flag alone, and a wrap at the same edge as a clear leaves the flag set.
- R10: `irq` is high exactly when some overflow flag is set and its mask bit is set. Mask bits are set at address 3, cleared at address 4, and read at both.
- R11: A software write to a counter word (addresses 6, 7, 8 to 11) loads the data at that edge in place of any increment.
- R12: With the run bit at 0, no counter and no divider changes, whatever the events and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| events | input | 16 | Event pulses from the core, one per bit |
| irq | output | 1 | Level interrupt for masked overflow flags |

## Verification
The assertions assume that `events`, `reg_we`, `reg_addr` and `reg_wdata` are known and stable at every rising edge once reset is released. They also assume that exactly one register is addressed per write. The stimulus changes these inputs only on falling edges and drives no X after reset. Its random phases pick every address, including the control address, so the strobes, the write-one-to-clear flags and counter loads all land at the same edges as increments and wraps. The bench model resolves those collisions by the same priority rules listed above.

// File: rtl/perfmon_pkg.sv
`timescale 1ns/1ps
// perfmon_pkg: register addresses and control bit positions shared by the
// performance counter unit. Assumes a 4-bit word address space.
package perfmon_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVF     = 4'd5;
    localparam logic [ADDR_W-1:0] A_CYC_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CYC_HI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_EVT_VAL = 4'd8;
    localparam logic [ADDR_W-1:0] A_EVT_SEL = 4'd12;

    localparam int CB_RUN     = 0;
    localparam int CB_CLR_EVT = 1;
    localparam int CB_CLR_CYC = 2;
    localparam int CB_DIV     = 3;
endpackage

// File: rtl/perfmon_evt_counter.sv
`timescale 1ns/1ps
// perfmon_evt_counter: one programmable event counter with its own selector.
// Assumes count_ok already combines the run bit and the per-counter enable.
// Priority at an edge: clear, then software load, then increment.
module perfmon_evt_counter #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  count_ok,
    input  logic [(1<<SEL_W)-1:0] events,
    input  logic                  sel_we,
    input  logic [SEL_W-1:0]      sel_wdata,
    input  logic                  val_we,
    input  logic [CNT_W-1:0]      val_wdata,
    input  logic                  clr,
    output logic [CNT_W-1:0]      count_q,
    output logic [SEL_W-1:0]      sel_q,
    output logic                  ovf_pulse
);
    logic hit;

    // pick the chosen event and qualify it
    always_comb begin
        hit       = count_ok & events[sel_q];
        ovf_pulse = hit & ~clr & ~val_we & (&count_q);
    end

    // selector register
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= sel_wdata;
    end

    // counter with clear, load and increment
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (clr)    count_q <= '0;
        else if (val_we) count_q <= val_wdata;
        else if (hit)    count_q <= count_q + 1'b1;
    end

    // R2
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ok && events[sel_q] && !clr && !val_we) |=> count_q == $past(count_q) + 1'b1);
    // R2
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(count_ok && events[sel_q]) && !clr && !val_we) |=> $stable(count_q));
    // R8
    evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> count_q == '0);
    // R11
    evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && !clr) |=> count_q == $past(val_wdata));
endmodule

// File: rtl/perfmon_cyc_counter.sv
`timescale 1ns/1ps
// perfmon_cyc_counter: wide cycle counter with an optional divide-by-2^PRESC_W
// prescaler. Assumes run already combines the run bit and the counter enable.
// The prescaler advances only on enabled clocks while divide mode is on.
module perfmon_cyc_counter #(
    parameter int HALF_W  = 32,
    parameter int PRESC_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                div,
    input  logic                clr,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count_q,
    output logic                ovf_pulse
);
    localparam int FULL_W = 2 * HALF_W;

    logic [PRESC_W-1:0] presc_q;
    logic               tick;

    // step request: every enabled clock, or prescaler terminal count
    always_comb begin
        tick      = run & (~div | (&presc_q));
        ovf_pulse = tick & ~clr & ~lo_we & ~hi_we & (&count_q);
    end

    // prescaler
    always_ff @(posedge clk) begin
        if (!rst_n)          presc_q <= '0;
        else if (clr)        presc_q <= '0;
        else if (run && div) presc_q <= presc_q + 1'b1;
    end

    // counter with clear, half-word loads and increment
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (clr)   count_q <= '0;
        else if (lo_we) count_q <= {count_q[FULL_W-1:HALF_W], wdata};
        else if (hi_we) count_q <= {wdata, count_q[HALF_W-1:0]};
        else if (tick)  count_q <= count_q + 1'b1;
    end

    // R4
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div && !clr && !lo_we && !hi_we) |=> count_q == $past(count_q) + 1'b1);
    // R5
    cyc_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div && !(&presc_q) && !clr && !lo_we && !hi_we) |=> $stable(count_q));
    // R5
    presc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div && !clr) |=> presc_q == $past(presc_q) + 1'b1);
    // R6
    cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0 && presc_q == '0));
endmodule

// File: rtl/perfmon_ovf_irq.sv
`timescale 1ns/1ps
// perfmon_ovf_irq: sticky overflow flags with write-one-to-clear, the
// interrupt mask with set and clear writes, and the level interrupt.
// Assumes ovf_set pulses last one cycle. A set wins over a clear at one edge.
module perfmon_ovf_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ovf_set,
    input  logic         w1c_we,
    input  logic         ie_set_we,
    input  logic         ie_clr_we,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] ie_q,
    output logic         irq
);
    // sticky flags: clear requested bits, then merge new overflows
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(w1c_we ? wmask : '0)) | ovf_set;
    end

    // interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)         ie_q <= '0;
        else if (ie_set_we) ie_q <= ie_q | wmask;
        else if (ie_clr_we) ie_q <= ie_q & ~wmask;
    end

    // level interrupt from masked flags
    always_comb irq = |(flags_q & ie_q);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w1c_we |=> (flags_q & $past(flags_q)) == $past(flags_q));
    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set != '0) |=> (flags_q & $past(ovf_set)) == $past(ovf_set));
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);
endmodule

// File: rtl/perfmon_unit.sv
`timescale 1ns/1ps
// perfmon_unit: per-core performance monitor top. Holds the control and
// enable registers, decodes the word port, instantiates the event counters,
// the cycle counter and the overflow/interrupt logic, and muxes read data.
// Assumes N_EVT == 4 so counter words fill addresses 8..11 and selectors 12..15.
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int N_EVT   = 4,
    parameter int SEL_W   = 4,
    parameter int PRESC_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [(1<<SEL_W)-1:0] events,
    output logic                  irq
);
    localparam int N_CTR  = N_EVT + 1;
    localparam int CYC_IX = N_EVT;

    logic              run_q, div_q;
    logic [N_CTR-1:0]  en_q;
    logic [N_CTR-1:0]  ovf_set, flags, ie;
    logic              ctrl_we, clr_evt, clr_cyc;
    logic [DATA_W-1:0] evt_cnt [N_EVT];
    logic [SEL_W-1:0]  evt_sel [N_EVT];
    logic [2*DATA_W-1:0] cyc_cnt;

    // control decode: the strobes act at this edge and are never stored
    always_comb begin
        ctrl_we = reg_we && (reg_addr == A_CTRL);
        clr_evt = ctrl_we && reg_wdata[CB_CLR_EVT];
        clr_cyc = ctrl_we && reg_wdata[CB_CLR_CYC];
    end

    // run and divide bits of the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= 1'b0;
        end else if (ctrl_we) begin
            run_q <= reg_wdata[CB_RUN];
            div_q <= reg_wdata[CB_DIV];
        end
    end

    // per-counter enable mask with set and clear addresses
    always_ff @(posedge clk) begin
        if (!rst_n)                                en_q <= '0;
        else if (reg_we && reg_addr == A_EN_SET)   en_q <= en_q | reg_wdata[N_CTR-1:0];
        else if (reg_we && reg_addr == A_EN_CLR)   en_q <= en_q & ~reg_wdata[N_CTR-1:0];
    end

    generate
        for (genvar i = 0; i < N_EVT; i++) begin : g_evt
            localparam logic [ADDR_W-1:0] VAL_A = A_EVT_VAL + ADDR_W'(i);
            localparam logic [ADDR_W-1:0] SEL_A = A_EVT_SEL + ADDR_W'(i);
            perfmon_evt_counter #(
                .CNT_W(DATA_W),
                .SEL_W(SEL_W)
            ) u_evt (
                .clk      (clk),
                .rst_n    (rst_n),
                .count_ok (run_q & en_q[i]),
                .events   (events),
                .sel_we   (reg_we && reg_addr == SEL_A),
                .sel_wdata(reg_wdata[SEL_W-1:0]),
                .val_we   (reg_we && reg_addr == VAL_A),
                .val_wdata(reg_wdata),
                .clr      (clr_evt),
                .count_q  (evt_cnt[i]),
                .sel_q    (evt_sel[i]),
                .ovf_pulse(ovf_set[i])
            );
        end
    endgenerate

    perfmon_cyc_counter #(
        .HALF_W (DATA_W),
        .PRESC_W(PRESC_W)
    ) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q & en_q[CYC_IX]),
        .div      (div_q),
        .clr      (clr_cyc),
        .lo_we    (reg_we && reg_addr == A_CYC_LO),
        .hi_we    (reg_we && reg_addr == A_CYC_HI),
        .wdata    (reg_wdata),
        .count_q  (cyc_cnt),
        .ovf_pulse(ovf_set[CYC_IX])
    );

    perfmon_ovf_irq #(
        .N(N_CTR)
    ) u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_set  (ovf_set),
        .w1c_we   (reg_we && reg_addr == A_OVF),
        .ie_set_we(reg_we && reg_addr == A_IE_SET),
        .ie_clr_we(reg_we && reg_addr == A_IE_CLR),
        .wmask    (reg_wdata[N_CTR-1:0]),
        .flags_q  (flags),
        .ie_q     (ie),
        .irq      (irq)
    );

    // read data mux, combinational on the address
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_RUN] = run_q;
                reg_rdata[CB_DIV] = div_q;
            end
            A_EN_SET, A_EN_CLR: reg_rdata[N_CTR-1:0] = en_q;
            A_IE_SET, A_IE_CLR: reg_rdata[N_CTR-1:0] = ie;
            A_OVF:              reg_rdata[N_CTR-1:0] = flags;
            A_CYC_LO:           reg_rdata = cyc_cnt[DATA_W-1:0];
            A_CYC_HI:           reg_rdata = cyc_cnt[2*DATA_W-1:DATA_W];
            default:            reg_rdata = '0;
        endcase
        for (int i = 0; i < N_EVT; i++) begin
            if (reg_addr == A_EVT_VAL + ADDR_W'(i)) reg_rdata = evt_cnt[i];
            if (reg_addr == A_EVT_SEL + ADDR_W'(i)) reg_rdata = {{(DATA_W-SEL_W){1'b0}}, evt_sel[i]};
        end
    end

    // R12
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reg_we) |=> ($stable(cyc_cnt) && $stable(evt_cnt[0]) && $stable(evt_cnt[N_EVT-1])));
    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_EN_SET) |=> (en_q & $past(reg_wdata[N_CTR-1:0])) == $past(reg_wdata[N_CTR-1:0]));
    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_EN_CLR) |=> (en_q & $past(reg_wdata[N_CTR-1:0])) == '0);
    // R6
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (evt_cnt[0] == '0 && evt_cnt[N_EVT-1] == '0));
endmodule

// File: tb/perfmon_unit_tb.sv
`timescale 1ns/1ps
// perfmon_unit_tb: behavioural reference model compared on every clock,
// plus directed scenarios with hand-computed expectations.
module perfmon_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] ev_in = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;

    // reference model state
    bit [31:0] m_ev [4];
    bit [3:0]  m_sel [4];
    bit [63:0] m_cyc;
    int        m_presc;
    bit        m_run, m_div;
    bit [4:0]  m_en, m_ie, m_ovf;

    always #4 clk = ~clk;

    perfmon_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .events(ev_in), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return {28'd0, m_div, 2'b00, m_run};
            4'd1, 4'd2: return {27'd0, m_en};
            4'd3, 4'd4: return {27'd0, m_ie};
            4'd5: return {27'd0, m_ovf};
            4'd6: return m_cyc[31:0];
            4'd7: return m_cyc[63:32];
            4'd8, 4'd9, 4'd10, 4'd11: return m_ev[a - 4'd8];
            default: return {28'd0, m_sel[a - 4'd12]};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a == 4'd0) return "R6";
        if (a == 4'd1 || a == 4'd2) return "R7";
        if (a == 4'd3 || a == 4'd4) return "R10";
        if (a == 4'd5) return "R9";
        if (a == 4'd6 || a == 4'd7) return "R4";
        if (a < 4'd12) return "R2";
        return "R3";
    endfunction

    // model update at each rising edge from the inputs sampled there
    always @(posedge clk) begin
        bit [4:0] setf;
        bit inc, crun, ctick;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_ev[i] = 0; m_sel[i] = 0; end
            m_cyc = 0; m_presc = 0; m_run = 0; m_div = 0;
            m_en = 0; m_ie = 0; m_ovf = 0;
        end else begin
            setf = 0;
            for (int i = 0; i < 4; i++) begin
                inc = m_run && m_en[i] && ev_in[m_sel[i]];
                if (we && addr == 0 && wdata[1]) m_ev[i] = 0;
                else if (we && addr == 4'(8 + i)) m_ev[i] = wdata;
                else if (inc) begin
                    if (m_ev[i] == 32'hFFFF_FFFF) setf[i] = 1;
                    m_ev[i] = m_ev[i] + 1;
                end
            end
            crun  = m_run && m_en[4];
            ctick = crun && (!m_div || m_presc == 63);
            if (we && addr == 0 && wdata[2]) begin
                m_cyc = 0; m_presc = 0;
            end else begin
                if (crun && m_div) m_presc = (m_presc + 1) % 64;
                if (we && addr == 6) m_cyc = {m_cyc[63:32], wdata};
                else if (we && addr == 7) m_cyc = {wdata, m_cyc[31:0]};
                else if (ctick) begin
                    if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) setf[4] = 1;
                    m_cyc = m_cyc + 1;
                end
            end
            if (we && addr == 5) m_ovf = m_ovf & ~wdata[4:0];
            m_ovf = m_ovf | setf;
            if (we && addr == 1) m_en = m_en | wdata[4:0];
            if (we && addr == 2) m_en = m_en & ~wdata[4:0];
            if (we && addr == 3) m_ie = m_ie | wdata[4:0];
            if (we && addr == 4) m_ie = m_ie & ~wdata[4:0];
            for (int i = 0; i < 4; i++) if (we && addr == 4'(12 + i)) m_sel[i] = wdata[3:0];
            if (we && addr == 0) begin m_run = wdata[0]; m_div = wdata[3]; end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            check(rdata === model_read(addr), tag_of(addr), rdata, model_read(addr));
            check(irq === |(m_ovf & m_ie), "R10", {31'd0, irq}, {31'd0, |(m_ovf & m_ie)});
        end
    end

    task automatic drv_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); we = 0; end
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); we = 0; addr = a; #2;
        check(rdata === e, tag, rdata, e);
    endtask

    task automatic expect_irq(input bit e, input string tag);
        @(negedge clk); we = 0; #2;
        check(irq === e, tag, {31'd0, irq}, {31'd0, e});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // R1: reset state everywhere
        for (int a = 0; a < 16; a++) expect_rd(4'(a), 32'd0, "R1");
        expect_irq(0, "R1");

        // R12: enables on, run off, events active -> nothing moves
        drv_write(4'd1, 32'h1F);
        ev_in = '1;
        idle(10);
        ev_in = '0;
        expect_rd(4'd8, 32'd0, "R12");
        expect_rd(4'd6, 32'd0, "R12");

        // R3 / R2: selectors and random events
        drv_write(4'd12, 32'd0);
        drv_write(4'd13, 32'd5);
        drv_write(4'd14, 32'd15);
        drv_write(4'd15, 32'd5);
        drv_write(4'd0, 32'h1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); we = 0; addr = 4'(i % 16); ev_in = 16'($urandom);
        end
        ev_in = '0;

        // R11 / R8: load wins over increment, then wrap sets flag
        ev_in = '1;
        drv_write(4'd9, 32'hFFFF_FFFE);
        expect_rd(4'd9, 32'hFFFF_FFFE, "R11");
        expect_rd(4'd9, 32'hFFFF_FFFF, "R2");
        expect_rd(4'd9, 32'd0, "R8");
        ev_in = '0;
        expect_rd(4'd5, 32'h2, "R8");
        expect_irq(0, "R10");
        drv_write(4'd3, 32'h2);
        expect_irq(1, "R10");
        drv_write(4'd5, 32'h0);
        expect_rd(4'd5, 32'h2, "R9");
        drv_write(4'd5, 32'h2);
        expect_rd(4'd5, 32'h0, "R9");
        expect_irq(0, "R10");

        // R9: wrap at the same edge as a clear keeps the flag
        drv_write(4'd9, 32'hFFFF_FFFF);
        ev_in = '1;
        drv_write(4'd5, 32'h2);
        idle(1);
        ev_in = '0;
        expect_rd(4'd5, 32'h2, "R9");
        expect_irq(1, "R10");
        drv_write(4'd5, 32'h1F);
        expect_rd(4'd5, 32'h0, "R9");

        // R6: clear strobe wins over increment; strobes read 0; writing 0 is inert
        ev_in = '1;
        drv_write(4'd0, 32'h3);
        expect_rd(4'd8, 32'd0, "R6");
        ev_in = '0;
        expect_rd(4'd0, 32'h1, "R6");
        ev_in = '1;
        idle(1);
        ev_in = '0;
        drv_write(4'd0, 32'h1);
        expect_rd(4'd8, 32'd1, "R6");

        // R5: divide by 64 after a cycle clear
        drv_write(4'd0, 32'hD);
        idle(63);
        expect_rd(4'd6, 32'd0, "R5");
        expect_rd(4'd6, 32'd1, "R5");
        idle(63);
        expect_rd(4'd6, 32'd2, "R5");

        // R4 / R8: cycle counter undivided, loaded near the top, wraps
        drv_write(4'd0, 32'h1);
        drv_write(4'd7, 32'hFFFF_FFFF);
        drv_write(4'd6, 32'hFFFF_FFFE);
        expect_rd(4'd6, 32'hFFFF_FFFE, "R11");
        expect_rd(4'd7, 32'hFFFF_FFFF, "R4");
        expect_rd(4'd5, 32'h10, "R8");
        expect_rd(4'd7, 32'h0, "R8");
        drv_write(4'd5, 32'h1F);

        // R7: enable set/clear masks and per-counter gating
        drv_write(4'd2, 32'h1);
        expect_rd(4'd1, 32'h1E, "R7");
        drv_write(4'd1, 32'h0);
        expect_rd(4'd2, 32'h1E, "R7");
        ev_in = '1;
        idle(5);
        ev_in = '0;
        expect_rd(4'd8, 32'd1, "R7");
        drv_write(4'd1, 32'h1);
        drv_write(4'd3, 32'h1F);

        // random register traffic mixed with events
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            we = ($urandom % 4) == 0;
            addr = 4'($urandom % 16);
            wdata = $urandom;
            if (addr == 4'd0) wdata[0] = ($urandom % 8) != 0;
            if (addr == 4'd2 && ($urandom % 2) == 0) wdata = 0;
            ev_in = 16'($urandom);
        end
        idle(2);
        finish_run();
    end
endmodule